// File: doc/BRIEF.md
# Oscillator Watchdog with Clock Fallback

This block supervises the external input clock while the core runs straight from it, with the PLL bypassed. A counter runs on the PLL base clock. Each rising edge of the external clock, brought into the base domain, clears that counter. If the external clock stops, the counter reaches a threshold and the block declares a failure. It then moves the core clock over to the PLL base clock, which keeps running on its own, and raises a sticky interrupt request flag.

The switchover uses a two-stage handover. The external clock gate is removed first. The base clock gate opens only after two falling edges of the base clock, so no shortened pulse reaches the core clock. Once the block has fallen back it stays on the base clock until reset. The flag is cleared by a software write pulse on `flag_clr`, which is synchronous to the base clock. A low level on the enable pin `wd_en` switches the whole function off.

The block carries no data stream, so there is no valid/ready interface. Every pin is plain control or status.

Top module: `owd_top`

## Requirements
- R1: While `rst_n` is low and right after it rises, `irq_flag` and `use_base` are 0. `core_clk` is 0 until the first falling edge of `ext_clk` after reset, and from then on it follows `ext_clk`.
- R2: While `ext_clk` keeps toggling with a period well below `THRESH` base-clock cycles, no failure is declared, `irq_flag` stays 0 and `use_base` stays 0.
- R3: The miss counter is cleared on the base-clock edge after a rising edge of `ext_clk` is seen through a two-flop synchronizer. Otherwise it increments once per base-clock edge and saturates at `THRESH` (default 16). Failure is declared on the edge where the counter becomes `THRESH`.
- R4: `irq_flag` becomes 1 on the same base-clock edge that declares the failure.
- R5: On failure the external clock gate drops at once. `use_base` rises after two more falling edges of `base_clk`, and from then on `core_clk` equals `base_clk`. The two gates are never open together.
- R6: `irq_flag` stays 1 until a base-clock edge that samples `flag_clr` = 1. If the failure is declared on the same edge that samples `flag_clr` = 1, the set wins.
- R7: Once declared, the failure and `use_base` = 1 persist until reset. They are not affected by `ext_clk` resuming, by `flag_clr`, or by `wd_en` or `direct_drv` dropping.
- R8: While `wd_en` is 0, the miss counter is held at zero and no failure and no switchover occur. A failure can be declared only after `wd_en` returns to 1.
- R9: While `direct_drv` is 0 (core not in direct-drive mode), the block behaves as in R8. Monitoring needs both `wd_en` and `direct_drv` at 1.
- R10: The block detects a stopped `ext_clk` whether the clock is stuck low or stuck high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_clk | input | 1 | PLL base clock; runs the supervisor and is the fallback source |
| ext_clk | input | 1 | External input clock being supervised |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en | input | 1 | Enable pin; high turns the watchdog on |
| direct_drv | input | 1 | High while the core is fed directly from `ext_clk` |
| flag_clr | input | 1 | Software clear of `irq_flag`, sampled on `base_clk` |
| core_clk | output | 1 | Gated core clock from the selected source |
| use_base | output | 1 | High once the base clock gate is open |
| irq_flag | output | 1 | Sticky clock-failure interrupt request |

## Verification
The bound checker checks these on every base-clock edge: the counter never passes the threshold and is zero after a disabled cycle; the two clock gates are never open together; the failure and the base selection are sticky; the flag is set whenever a failure is declared and falls only after a clear; and a failure is declared only while monitoring is enabled. Several things can only be shown by the bench's scenarios against its cycle model. These are the exact detection latency after the clock stops low or high, the two-falling-edge handover delay, the gated clock waveform before and after fallback, and the set-over-clear priority when the clear is held through a failure.

// File: rtl/owd_pkg.sv
package owd_pkg;
  localparam int unsigned OWD_DEF_THRESH = 16;
  localparam int unsigned OWD_DEF_SYNC   = 2;
  localparam int unsigned OWD_HAND_STAGES = 2;

  function automatic int unsigned owd_cnt_w(input int unsigned lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/owd_sync.sv
module owd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owd_miss_det.sv
module owd_miss_det #(
  parameter int unsigned THRESH = owd_pkg::OWD_DEF_THRESH,
  parameter int unsigned SYNC   = owd_pkg::OWD_DEF_SYNC,
  localparam int unsigned CW    = owd_pkg::owd_cnt_w(THRESH)
) (
  input  logic          base_clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          active,
  output logic [CW-1:0] cnt,
  output logic          fail,
  output logic          fail_hit
);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic          ext_s;
  logic          ext_d;
  logic          seen_rise;
  logic [CW-1:0] cnt_nxt;
  logic          fail_nxt;

  owd_sync #(.STAGES(SYNC)) u_ext_sync (
    .clk  (base_clk),
    .rst_n(rst_n),
    .d    (ext_clk),
    .q    (ext_s)
  );

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) ext_d <= 1'b0;
    else        ext_d <= ext_s;
  end

  assign seen_rise = ext_s & ~ext_d;

  always_comb begin
    if (!active || seen_rise) cnt_nxt = '0;
    else if (cnt != LIMIT)    cnt_nxt = cnt + 1'b1;
    else                      cnt_nxt = cnt;
  end

  assign fail_nxt = fail | (active & (cnt_nxt == LIMIT));
  assign fail_hit = fail_nxt & ~fail;

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fail <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      fail <= fail_nxt;
    end
  end
endmodule

// File: rtl/owd_clk_switch.sv
module owd_clk_switch #(
  parameter int unsigned HAND = owd_pkg::OWD_HAND_STAGES
) (
  input  logic ext_clk,
  input  logic base_clk,
  input  logic rst_n,
  input  logic fail,
  output logic ext_en,
  output logic base_en,
  output logic core_clk
);
  logic ext_run;
  logic base_clk_n;

  // External gate opens on a falling edge so the first pulse is whole.
  always_ff @(negedge ext_clk or negedge rst_n) begin
    if (!rst_n) ext_run <= 1'b0;
    else        ext_run <= 1'b1;
  end

  // The failed clock may never tick again, so its gate drops at once.
  assign ext_en = ext_run & ~fail;

  assign base_clk_n = ~base_clk;

  // Base gate opens only after the handover stages on falling base edges.
  owd_sync #(.STAGES(HAND)) u_hand (
    .clk  (base_clk_n),
    .rst_n(rst_n),
    .d    (fail),
    .q    (base_en)
  );

  assign core_clk = (ext_clk & ext_en) | (base_clk & base_en);
endmodule

// File: rtl/owd_irq_flag.sv
module owd_irq_flag (
  input  logic base_clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/owd_top.sv
module owd_top #(
  parameter int unsigned THRESH = owd_pkg::OWD_DEF_THRESH,
  parameter int unsigned SYNC   = owd_pkg::OWD_DEF_SYNC,
  localparam int unsigned CW    = owd_pkg::owd_cnt_w(THRESH)
) (
  input  logic base_clk,
  input  logic ext_clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic direct_drv,
  input  logic flag_clr,
  output logic core_clk,
  output logic use_base,
  output logic irq_flag
);
  logic          mon_active;
  logic [CW-1:0] miss_cnt;
  logic          fail_q;
  logic          fail_hit;
  logic          ext_en;
  logic          base_en;

  assign mon_active = wd_en & direct_drv;

  owd_miss_det #(.THRESH(THRESH), .SYNC(SYNC)) u_det (
    .base_clk(base_clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .active  (mon_active),
    .cnt     (miss_cnt),
    .fail    (fail_q),
    .fail_hit(fail_hit)
  );

  owd_clk_switch u_sw (
    .ext_clk (ext_clk),
    .base_clk(base_clk),
    .rst_n   (rst_n),
    .fail    (fail_q),
    .ext_en  (ext_en),
    .base_en (base_en),
    .core_clk(core_clk)
  );

  owd_irq_flag u_flag (
    .base_clk(base_clk),
    .rst_n   (rst_n),
    .set     (fail_hit),
    .clr     (flag_clr),
    .flag    (irq_flag)
  );

  assign use_base = base_en;
endmodule

// File: rtl/owd_chk.sv
module owd_chk #(
  parameter int unsigned THRESH = 16,
  parameter int unsigned CW     = 5
) (
  input logic          base_clk,
  input logic          rst_n,
  input logic          wd_en,
  input logic          direct_drv,
  input logic          flag_clr,
  input logic          irq_flag,
  input logic          use_base,
  input logic          ext_en,
  input logic          base_en,
  input logic          fail_q,
  input logic [CW-1:0] miss_cnt
);
  assert_cnt_bound_R3: assert property (@(posedge base_clk) disable iff (!rst_n)
    miss_cnt <= CW'(THRESH));

  assert_hold_zero_R8: assert property (@(posedge base_clk) disable iff (!rst_n)
    !(wd_en && direct_drv) |=> miss_cnt == '0);

  assert_one_gate_R5: assert property (@(posedge base_clk) disable iff (!rst_n)
    $onehot0({ext_en, base_en}));

  assert_fail_sticky_R7: assert property (@(posedge base_clk) disable iff (!rst_n)
    fail_q |=> fail_q);

  assert_base_sticky_R7: assert property (@(posedge base_clk) disable iff (!rst_n)
    use_base |=> use_base);

  assert_flag_on_fail_R4: assert property (@(posedge base_clk) disable iff (!rst_n)
    $rose(fail_q) |-> irq_flag);

  assert_flag_clear_R6: assert property (@(posedge base_clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(flag_clr));

  assert_fail_enabled_R9: assert property (@(posedge base_clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(wd_en && direct_drv));
endmodule

bind owd_top owd_chk #(.THRESH(THRESH), .CW(CW)) u_chk (
  .base_clk  (base_clk),
  .rst_n     (rst_n),
  .wd_en     (wd_en),
  .direct_drv(direct_drv),
  .flag_clr  (flag_clr),
  .irq_flag  (irq_flag),
  .use_base  (use_base),
  .ext_en    (ext_en),
  .base_en   (base_en),
  .fail_q    (fail_q),
  .miss_cnt  (miss_cnt)
);

// File: tb/owd_top_tb.sv
module owd_top_tb;
  localparam int TH = 16;

  logic base_clk = 1'b0;
  logic ext_clk  = 1'b0;
  logic rst_n    = 1'b0;
  logic wd_en    = 1'b1;
  logic direct_drv = 1'b1;
  logic flag_clr = 1'b0;
  logic core_clk, use_base, irq_flag;

  bit ext_run = 1'b1;
  bit ext_lvl = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference model state
  int m_cnt = 0;
  bit h1, h2, h3, m_fail, d1, d2, m_irq, m_exton;

  always #4 base_clk = ~base_clk;

  initial begin
    #1;
    forever begin
      if (ext_run) ext_clk = ~ext_clk;
      else         ext_clk = ext_lvl;
      #10;
    end
  end

  owd_top #(.THRESH(TH)) u_dut (
    .base_clk  (base_clk),
    .ext_clk   (ext_clk),
    .rst_n     (rst_n),
    .wd_en     (wd_en),
    .direct_drv(direct_drv),
    .flag_clr  (flag_clr),
    .core_clk  (core_clk),
    .use_base  (use_base),
    .irq_flag  (irq_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // External gate model: opens on first ext falling edge after reset
  always @(negedge ext_clk or negedge rst_n) begin
    if (!rst_n) m_exton = 1'b0;
    else        m_exton = 1'b1;
  end

  // Behavioural cycle model on the base clock
  always @(posedge base_clk) begin
    bit act_b, rise_b, fnew;
    if (!rst_n) begin
      m_cnt = 0; h1 = 0; h2 = 0; h3 = 0;
      m_fail = 0; d1 = 0; d2 = 0; m_irq = 0;
    end else begin
      act_b  = wd_en & direct_drv;
      rise_b = h2 & !h3;
      if (!act_b || rise_b) m_cnt = 0;
      else if (m_cnt < TH)  m_cnt = m_cnt + 1;
      fnew = m_fail | (act_b && m_cnt == TH);
      d2 = d1;
      d1 = m_fail;
      if (fnew && !m_fail) m_irq = 1'b1;
      else if (flag_clr)   m_irq = 1'b0;
      m_fail = fnew;
      h3 = h2; h2 = h1; h1 = ext_clk;
    end
  end

  // Per-cycle comparison, away from the edge; also the watchdog
  always @(posedge base_clk) begin
    bit exp_core;
    #2;
    cyc++;
    exp_core = (m_exton & !m_fail & ext_clk) | d2;
    chk(irq_flag == m_irq, "R4 R6 irq_flag vs model", irq_flag, m_irq);
    chk(use_base == d2, "R5 R7 use_base vs model", use_base, d2);
    chk(core_clk == exp_core, "R5 core_clk vs model", core_clk, exp_core);
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge base_clk);
    #3;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_run = 1'b1; ext_lvl = 1'b0;
    wd_en = 1'b1; direct_drv = 1'b1; flag_clr = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(6);
  endtask

  initial begin
    int n;
    bit seen;
    do_reset();
    chk(irq_flag == 1'b0, "R1 irq_flag after reset", irq_flag, 0);
    chk(use_base == 1'b0, "R1 use_base after reset", use_base, 0);

    step(200);
    chk(irq_flag == 1'b0, "R2 no failure while clock runs", irq_flag, 0);
    chk(use_base == 1'b0, "R2 no switchover while clock runs", use_base, 0);

    // R3: stop low, measure detection latency
    ext_lvl = 1'b0; ext_run = 1'b0;
    n = 0;
    while (!irq_flag && n < 100) begin
      step(1);
      n++;
    end
    chk(n >= TH - 3 && n <= TH + 6, "R3 detection latency", n, TH);
    chk(irq_flag == 1'b1, "R4 flag set on failure", irq_flag, 1);
    step(3);
    chk(use_base == 1'b1, "R5 base selected after handover", use_base, 1);
    chk(core_clk == base_clk, "R5 core_clk high phase", core_clk, base_clk);
    #4;
    chk(core_clk == base_clk, "R5 core_clk low phase", core_clk, base_clk);
    step(1);

    // R6: software clear
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk(irq_flag == 1'b0, "R6 flag cleared", irq_flag, 0);
    chk(use_base == 1'b1, "R7 selection kept after clear", use_base, 1);

    // R7: clock resumes, enable drops
    ext_run = 1'b1;
    step(100);
    chk(use_base == 1'b1, "R7 selection kept after clock resumes", use_base, 1);
    chk(irq_flag == 1'b0, "R7 flag stays clear", irq_flag, 0);
    wd_en = 1'b0;
    step(10);
    chk(use_base == 1'b1, "R7 selection kept with wd_en low", use_base, 1);

    // R8: disabled by pin
    do_reset();
    wd_en = 1'b0; ext_run = 1'b0;
    step(200);
    chk(irq_flag == 1'b0, "R8 no flag while disabled", irq_flag, 0);
    chk(use_base == 1'b0, "R8 no switchover while disabled", use_base, 0);
    wd_en = 1'b1;
    step(TH + 10);
    chk(irq_flag == 1'b1, "R8 detection after enable", irq_flag, 1);

    // R9: not in direct drive
    do_reset();
    direct_drv = 1'b0; ext_run = 1'b0;
    step(200);
    chk(irq_flag == 1'b0, "R9 no flag outside direct drive", irq_flag, 0);
    chk(use_base == 1'b0, "R9 no switchover outside direct drive", use_base, 0);
    direct_drv = 1'b1;
    step(TH + 10);
    chk(irq_flag == 1'b1, "R9 detection in direct drive", irq_flag, 1);

    // R10: stuck high
    do_reset();
    ext_lvl = 1'b1; ext_run = 1'b0;
    step(TH + 10);
    chk(irq_flag == 1'b1, "R10 stuck-high detected", irq_flag, 1);
    step(3);
    chk(use_base == 1'b1, "R10 stuck-high switchover", use_base, 1);

    // R6: set wins over a held clear
    do_reset();
    flag_clr = 1'b1; ext_lvl = 1'b0; ext_run = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < TH + 12; i++) begin
      step(1);
      if (irq_flag) seen = 1'b1;
    end
    chk(seen == 1'b1, "R6 set wins over clear", seen, 1);
    chk(irq_flag == 1'b0, "R6 held clear removes flag", irq_flag, 0);
    chk(use_base == 1'b1, "R7 switchover despite clear", use_base, 1);
    flag_clr = 1'b0;
    step(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule